// File: doc/BRIEF.md
# Doorbell Page Write Decoder

This block sits behind the register port of one 4 KB doorbell page. Software rings a queue by writing a single 32-bit word. The block works out from the byte offset which doorbell was rung. It then pulls out the fields that belong to that doorbell's format and presents them for one cycle as a decoded event. Each event carries a kind code, the queue id, the count, any flag bits, and the index of the protection domain whose page took the write.

The page is split into 32-byte slots. Ten of them, starting at byte offset 64, are doorbells. Only the first word of each doorbell slot is acted on, and everything else in the page is inert. The completion/event queue doorbell has reserved bits. A write to it that sets any of them is not executed: the block raises an error pulse carrying the queue id and the page index instead. The decoder holds no queue state. One write is decoded per cycle, and each result appears on the cycle after the write.

Top module: `dbell_page_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises with no write, every output is zero.
- R2: A write at byte offset 64 + 32·k (k = 0..9) gives a one-cycle `ev_valid` on the next cycle, with `ev_kind` = k. The kinds in order are: 0 RDMA send queue, 1 storage work-request post, 2 Ethernet transmit, 3 RDMA receive, 4 storage default-PDU, 5 TPM receive, 6 Ethernet receive, 7 completion/event queue, 8 management ring, 9 bootstrap mailbox.
- R3: A write produces no pulse on either output when any of these holds: the offset has nonzero bits [4:0], the offset is below 64, or the offset is 384 or above.
- R4: For kinds 0, 2 and 8, `ev_qid` = data[10:0] and `ev_count` = data[29:16]. All flags and `ev_index` are zero.
- R5: For kinds 3 and 6, `ev_qid` = data[9:0], `ev_inval` = data[23] and `ev_count` = data[31:24].
- R6: For kind 7 with bits [13:10] and [31:29] all zero, `ev_qid` = data[9:0], `ev_rearm` = data[14], `ev_event` = data[15] and `ev_count` = data[28:16].
- R7: For kind 7 with any bit of [13:10] or [31:29] set, there is no `ev_valid`. Instead `err_valid` pulses once, with `err_qid` = data[9:0] and `err_pd` = the write's page index.
- R8: For kind 1, `ev_qid` = data[9:0], `ev_index` = data[23:16] and `ev_count` = data[31:24].
- R9: For kind 4, `ev_qid` = data[9:0], `ev_rearm` = data[14], `ev_event` = data[15] and `ev_count` = data[29:16]. For kind 5, `ev_qid` = data[9:0], `ev_count` = data[26:16] and `ev_index` = data[31:27].
- R10: For kind 9, `ev_hi` = data[1] and `ev_mbox_addr` = data[31:2]. Bit 0 is ignored.
- R11: Every event and every error carries the `wr_pd` value of the write that caused it.
- R12: Each write gives at most one pulse, and `ev_valid` and `err_valid` are never high together. When `ev_valid` is low, all `ev_*` fields are zero. When `err_valid` is low, `err_qid` and `err_pd` are zero. Back-to-back writes each give their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 12 | Byte offset within the page |
| wr_data | input | 32 | Written word |
| wr_pd | input | 5 | Protection-domain index of the page |
| ev_valid | output | 1 | Decoded doorbell event |
| ev_kind | output | 4 | Doorbell kind code |
| ev_pd | output | 5 | Page index of the event |
| ev_qid | output | 11 | Queue or connection id |
| ev_count | output | 14 | Posted or popped count |
| ev_index | output | 8 | Work-request index or segment count |
| ev_rearm | output | 1 | Rearm flag |
| ev_event | output | 1 | Event flag |
| ev_inval | output | 1 | Invalidate flag |
| ev_hi | output | 1 | Mailbox upper-half flag |
| ev_mbox_addr | output | 30 | Mailbox address bits |
| err_valid | output | 1 | Rejected completion doorbell |
| err_pd | output | 5 | Page index of the rejected write |
| err_qid | output | 10 | Queue id of the rejected write |

## Verification
Some properties are checked on every cycle:
- the two pulses are never high together;
- idle outputs are zero;
- every pulse follows a write;
- the page index is carried through;
- an executed completion doorbell had clean reserved bits, and every error came from the completion slot.

Other behaviour only the bench's scenarios can show: that each of the ten slots is routed to the right kind, that every field lands at the right bit position, and that writes to non-head words and to reserved offsets are dropped. Those are checked against a reference model under random writes, and by directed writes at the boundaries of the doorbell region.

// File: rtl/dbell_page_decoder.sv
module dbell_page_decoder #(
  parameter int PD_W        = 5,
  parameter int ADDR_W      = 12,
  parameter int SLOT_SHIFT  = 5,
  parameter int FIRST_SLOT  = 2,
  parameter int NUM_SLOTS   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [PD_W-1:0]   wr_pd,
  output logic              ev_valid,
  output logic [3:0]        ev_kind,
  output logic [PD_W-1:0]   ev_pd,
  output logic [10:0]       ev_qid,
  output logic [13:0]       ev_count,
  output logic [7:0]        ev_index,
  output logic              ev_rearm,
  output logic              ev_event,
  output logic              ev_inval,
  output logic              ev_hi,
  output logic [29:0]       ev_mbox_addr,
  output logic              err_valid,
  output logic [PD_W-1:0]   err_pd,
  output logic [9:0]        err_qid
);

  localparam int SIDX_W = ADDR_W - SLOT_SHIFT;
  localparam logic [SIDX_W-1:0] SLOT_LO = SIDX_W'(FIRST_SLOT);
  localparam logic [SIDX_W-1:0] SLOT_HI = SIDX_W'(FIRST_SLOT + NUM_SLOTS);

  localparam logic [3:0] K_RSQ  = 4'd0;
  localparam logic [3:0] K_WRB  = 4'd1;
  localparam logic [3:0] K_ETX  = 4'd2;
  localparam logic [3:0] K_RRQ  = 4'd3;
  localparam logic [3:0] K_PDU  = 4'd4;
  localparam logic [3:0] K_TPM  = 4'd5;
  localparam logic [3:0] K_ERX  = 4'd6;
  localparam logic [3:0] K_CQ   = 4'd7;
  localparam logic [3:0] K_MGT  = 4'd8;
  localparam logic [3:0] K_MBOX = 4'd9;

  logic [SIDX_W-1:0] slot_raw;
  logic              at_head, in_region, hit, cq_bad, take_ev, take_err;
  logic [3:0]        kind;

  assign slot_raw  = wr_addr[ADDR_W-1:SLOT_SHIFT];
  assign at_head   = wr_addr[SLOT_SHIFT-1:0] == '0;
  assign in_region = (slot_raw >= SLOT_LO) && (slot_raw < SLOT_HI);
  assign kind      = 4'(slot_raw - SLOT_LO);
  assign hit       = wr_en && at_head && in_region;
  assign cq_bad    = (wr_data[13:10] != 4'd0) || (wr_data[31:29] != 3'd0);
  assign take_err  = hit && (kind == K_CQ) && cq_bad;
  assign take_ev   = hit && !take_err;

  logic [10:0] n_qid;
  logic [13:0] n_count;
  logic [7:0]  n_index;
  logic        n_rearm, n_event, n_inval, n_hi;
  logic [29:0] n_mbox;

  always_comb begin
    n_qid   = 11'd0;
    n_count = 14'd0;
    n_index = 8'd0;
    n_rearm = 1'b0;
    n_event = 1'b0;
    n_inval = 1'b0;
    n_hi    = 1'b0;
    n_mbox  = 30'd0;
    unique case (kind)
      K_RSQ, K_ETX, K_MGT: begin
        n_qid   = wr_data[10:0];
        n_count = wr_data[29:16];
      end
      K_RRQ, K_ERX: begin
        n_qid   = {1'b0, wr_data[9:0]};
        n_inval = wr_data[23];
        n_count = {6'd0, wr_data[31:24]};
      end
      K_CQ: begin
        n_qid   = {1'b0, wr_data[9:0]};
        n_rearm = wr_data[14];
        n_event = wr_data[15];
        n_count = {1'b0, wr_data[28:16]};
      end
      K_WRB: begin
        n_qid   = {1'b0, wr_data[9:0]};
        n_index = wr_data[23:16];
        n_count = {6'd0, wr_data[31:24]};
      end
      K_PDU: begin
        n_qid   = {1'b0, wr_data[9:0]};
        n_rearm = wr_data[14];
        n_event = wr_data[15];
        n_count = wr_data[29:16];
      end
      K_TPM: begin
        n_qid   = {1'b0, wr_data[9:0]};
        n_count = {3'd0, wr_data[26:16]};
        n_index = {3'd0, wr_data[31:27]};
      end
      K_MBOX: begin
        n_hi    = wr_data[1];
        n_mbox  = wr_data[31:2];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid     <= 1'b0;
      ev_kind      <= '0;
      ev_pd        <= '0;
      ev_qid       <= '0;
      ev_count     <= '0;
      ev_index     <= '0;
      ev_rearm     <= 1'b0;
      ev_event     <= 1'b0;
      ev_inval     <= 1'b0;
      ev_hi        <= 1'b0;
      ev_mbox_addr <= '0;
      err_valid    <= 1'b0;
      err_pd       <= '0;
      err_qid      <= '0;
    end else begin
      ev_valid     <= take_ev;
      ev_kind      <= take_ev ? kind    : 4'd0;
      ev_pd        <= take_ev ? wr_pd   : '0;
      ev_qid       <= take_ev ? n_qid   : 11'd0;
      ev_count     <= take_ev ? n_count : 14'd0;
      ev_index     <= take_ev ? n_index : 8'd0;
      ev_rearm     <= take_ev && n_rearm;
      ev_event     <= take_ev && n_event;
      ev_inval     <= take_ev && n_inval;
      ev_hi        <= take_ev && n_hi;
      ev_mbox_addr <= take_ev ? n_mbox  : 30'd0;
      err_valid    <= take_err;
      err_pd       <= take_err ? wr_pd : '0;
      err_qid      <= take_err ? wr_data[9:0] : 10'd0;
    end
  end

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_valid && err_valid));

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |-> (ev_qid == 11'd0 && ev_count == 14'd0 && ev_index == 8'd0 &&
                   ev_mbox_addr == 30'd0 && !ev_rearm && !ev_event && !ev_inval && !ev_hi));

  a_r3_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid || err_valid) |-> $past(wr_en));

  a_r11_pd_tag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_pd == $past(wr_pd));

  a_r6_clean_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == K_CQ) |-> ($past(wr_data[13:10]) == 4'd0 && $past(wr_data[31:29]) == 3'd0));

  a_r7_err_from_cq: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> ($past(wr_addr) == ADDR_W'((FIRST_SLOT + 7) << SLOT_SHIFT) && err_pd == $past(wr_pd)));

endmodule

// File: tb/dbell_page_decoder_tb.sv
`timescale 1ns/1ps
module dbell_page_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  wr_pd = '0;
  logic        ev_valid, ev_rearm, ev_event, ev_inval, ev_hi, err_valid;
  logic [3:0]  ev_kind;
  logic [4:0]  ev_pd, err_pd;
  logic [10:0] ev_qid;
  logic [13:0] ev_count;
  logic [7:0]  ev_index;
  logic [29:0] ev_mbox_addr;
  logic [9:0]  err_qid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dbell_page_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_pd(wr_pd), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_pd(ev_pd),
    .ev_qid(ev_qid), .ev_count(ev_count), .ev_index(ev_index), .ev_rearm(ev_rearm),
    .ev_event(ev_event), .ev_inval(ev_inval), .ev_hi(ev_hi), .ev_mbox_addr(ev_mbox_addr),
    .err_valid(err_valid), .err_pd(err_pd), .err_qid(err_qid));

  function automatic logic [92:0] observed();
    return {ev_valid, ev_kind, ev_pd, ev_qid, ev_count, ev_index, ev_rearm, ev_event,
            ev_inval, ev_hi, ev_mbox_addr, err_valid, err_pd, err_qid};
  endfunction

  function automatic logic [92:0] model(logic en, logic [11:0] a, logic [31:0] d, logic [4:0] pd);
    logic v = 1'b0, e = 1'b0, rr = 1'b0, ee = 1'b0, iv = 1'b0, hh = 1'b0;
    logic [3:0] k = 4'd0;
    logic [10:0] q = '0;
    logic [13:0] c = '0;
    logic [7:0] ix = '0;
    logic [29:0] mb = '0;
    logic [9:0] eq = '0;
    logic [4:0] vp = '0, ep = '0;
    if (en && a[4:0] == 5'd0 && a >= 12'd64 && a < 12'd384) begin
      k = 4'((a - 12'd64) / 12'd32);
      if (k == 4'd7 && (d[13:10] != 0 || d[31:29] != 0)) begin
        e = 1'b1; ep = pd; eq = d[9:0];
      end else begin
        v = 1'b1; vp = pd;
        case (k)
          4'd0, 4'd2, 4'd8: begin q = d[10:0]; c = d[29:16]; end
          4'd3, 4'd6: begin q = 11'(d[9:0]); iv = d[23]; c = 14'(d[31:24]); end
          4'd7: begin q = 11'(d[9:0]); rr = d[14]; ee = d[15]; c = 14'(d[28:16]); end
          4'd1: begin q = 11'(d[9:0]); ix = d[23:16]; c = 14'(d[31:24]); end
          4'd4: begin q = 11'(d[9:0]); rr = d[14]; ee = d[15]; c = d[29:16]; end
          4'd5: begin q = 11'(d[9:0]); c = 14'(d[26:16]); ix = 8'(d[31:27]); end
          default: begin hh = d[1]; mb = d[31:2]; end
        endcase
      end
    end
    if (!v) k = 4'd0;
    return {v, k, vp, q, c, ix, rr, ee, iv, hh, mb, e, ep, eq};
  endfunction

  function automatic string tag_of(logic [11:0] a, logic [31:0] d);
    int k;
    if (a[4:0] != 0 || a < 64 || a >= 384) return "R3";
    k = (a - 64) / 32;
    case (k)
      0, 2, 8: return "R4";
      3, 6:    return "R5";
      7:       return (d[13:10] != 0 || d[31:29] != 0) ? "R7" : "R6";
      1:       return "R8";
      4, 5:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [92:0] exp);
    checks++;
    if (observed() !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, observed(), exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [4:0] pd, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_pd = pd;
    @(negedge clk);
    check(tag, model(1'b1, a, d, pd));
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    wr_en = 1'b0; wr_addr = $urandom; wr_data = $urandom;
    @(negedge clk);
    check(tag, '0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b11));
    repeat (3) @(negedge clk);
    check("R1 in reset", '0);
    wr_en = 1'b1; wr_addr = 12'd64; wr_data = 32'hffff_ffff;
    @(negedge clk);
    check("R1 write held in reset", '0);
    wr_en = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", '0);

    // R2 sweep of every slot head, kind code 0..9
    for (int k = 0; k < 10; k++)
      wr(12'(64 + 32 * k), 32'h0000_0000 | (32'(k) << 16) | 32'(k + 1), 5'(k), "R2");
    idle("R12 pulse ends");

    // R3 boundaries
    wr(12'd60, 32'hffff_ffff, 5'd1, "R3 below region");
    wr(12'd32, 32'hffff_ffff, 5'd1, "R3 below region");
    wr(12'd384, 32'h1234_5678, 5'd1, "R3 past region");
    wr(12'd4092, 32'h1234_5678, 5'd1, "R3 page end");
    wr(12'd68, 32'h1234_5678, 5'd1, "R3 second word");
    wr(12'd382, 32'h1234_5678, 5'd1, "R3 slot tail");
    wr(12'd288 + 12'd2, 32'h0, 5'd1, "R3 unaligned");

    // R6/R7 completion corner cases
    wr(12'd288, 32'h1fff_c3ff, 5'd3, "R6 all fields set");
    wr(12'd288, 32'h0000_0400, 5'd4, "R7 bit10");
    wr(12'd288, 32'h8000_0000, 5'd5, "R7 bit31");
    wr(12'd288, 32'h2000_0001, 5'd6, "R7 bit29");
    wr(12'd96, 32'hffff_ffff, 5'd7, "R8 all ones");
    wr(12'd352, 32'hffff_fffd, 5'd8, "R10 hi clear");
    wr(12'd352, 32'h0000_0003, 5'd9, "R10 bit0 ignored");
    wr(12'd224, 32'hf800_0155, 5'd31, "R11 pd 31 tpm");
    idle("R12 idle after error");

    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      int sel = $urandom_range(0, 99);
      if (sel < 70)      a = 12'(64 + 32 * $urandom_range(0, 9));
      else if (sel < 85) a = 12'(64 + 32 * $urandom_range(0, 9) + 4 * $urandom_range(1, 7));
      else               a = 12'({$urandom_range(0, 1023), 2'b00});
      d = $urandom;
      if (a == 12'd288 && $urandom_range(0, 1) == 1) d = d & 32'h1fff_c3ff;
      wr(a, d, 5'($urandom), tag_of(a, d));
      if ($urandom_range(0, 4) == 0) idle("R12 random idle");
    end
    idle("R12 final idle");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule